// File: doc/BRIEF.md
# Colour Grading Curve Table Port

This block gives a host, through a narrow byte-wide register window, read and write access to a bank of colour-grading curves. There are six curves, each with 64 entries of 16 bits. The curves are hue-to-hue, hue-to-saturation, lightness-to-saturation, saturation-to-saturation, lightness-to-lightness and hue-to-lightness. The host does not address the curve memory directly. It first writes a switch byte that picks the curve and the access mode, then writes an index byte that picks the entry. It then moves the 16-bit value through a high data byte and a low data byte.

A write to the high byte only stages it. A write to the low byte joins the staged byte with the low byte, conditions the result for the selected curve's number format, and stores the whole entry in one step. In bulk mode, every access to the low byte moves the index forward by one and wraps from 63 to 0. The host can therefore stream a whole curve as high/low pairs without rewriting the index. Switch codes that name no curve are reserved: writes through them are dropped and data reads through them return zero. The block only keeps and serves the curve contents. Applying the curves to pixels happens elsewhere.

Top module: `cg_table_port`

## Requirements
- R1: The window has four byte registers: address 0 is the switch, 1 is the index, 2 is the data low byte and 3 is the data high byte. In the switch, bits 7:5 are the curve code, bits 4:1 are a page field, and bit 0 is the access mode (1 = bulk). A read of the switch returns the last byte written to it.
- R2: Only index bits 5:0 are kept. A read of the index returns those 6 bits with bits 7:6 as zero.
- R3: A write to address 3 only stages a byte and leaves the stored curves unchanged. A write to address 2 stores the conditioned value of {staged byte, written byte} into the selected entry. No other entry changes, and the staged byte is kept for later writes.
- R4: Read data appears on reg_rdata with rd_valid high in the cycle after reg_rd is sampled. A reg_rd sampled together with reg_wr is ignored and produces no rd_valid.
- R5: Codes 0 to 5 select six separate curves: 0 hue-hue, 1 hue-sat, 2 light-sat, 3 sat-sat, 4 light-light, 5 hue-light. The page field has no effect on which entry is addressed.
- R6: Codes 6 and 7 are reserved. Data writes through them change no stored entry, and data reads through them return 0.
- R7: In bulk mode, the index increases by one after each read or write of address 2, whatever the code. A high-byte access never moves the index, and in normal mode (bit 0 = 0) the index moves only when written.
- R8: A bulk-mode step from index 63 gives index 0.
- R9: Hue-hue entries are 14-bit signed: bits 15:14 of the stored value are copies of bit 13.
- R10: Saturation curves (codes 1, 2 and 3) store an unsigned value; anything above 1280 is stored as 1280.
- R11: Lightness curves (codes 4 and 5) store a signed value clamped to -4096..4095.
- R12: After reset, the switch, the index, the staged byte, every curve entry and rd_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the byte window |
| reg_rd | input | 1 | Read strobe; ignored when reg_wr is also high |
| reg_addr | input | 2 | Window register select (0 switch, 1 index, 2 low, 3 high) |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte, registered |
| rd_valid | output | 1 | High for one cycle when reg_rdata carries a read result |

## Verification
The checker watches the index on every cycle. It checks that the index only steps in bulk mode, steps by exactly one, wraps at the top, takes the written low bits on an index write, and otherwise holds. It also checks that reads answer exactly one cycle later, that a read colliding with a write is dropped, and that no commit happens under a reserved code and no data is returned through one. Whether values land in the right curve and entry, are conditioned correctly per curve format, and leave their neighbours alone can only be shown by the bench. It writes through one curve and reads back through others, and checks each result against its own model of the six curves.

// File: rtl/cg_pkg.sv
package cg_pkg;

  localparam int ENTRY_W  = 16;
  localparam int CODE_W   = 3;
  localparam int SAT_MAX  = 1280;
  localparam int LIT_MAX  = 4095;
  localparam int LIT_MIN  = -4096;

  typedef enum logic [1:0] {
    WIN_SWITCH = 2'd0,
    WIN_INDEX  = 2'd1,
    WIN_LO     = 2'd2,
    WIN_HI     = 2'd3
  } win_addr_e;

  typedef enum logic [1:0] {
    FMT_HUE,
    FMT_SAT,
    FMT_LIT,
    FMT_NONE
  } curve_fmt_e;

  function automatic curve_fmt_e cg_fmt(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:                 return FMT_HUE;
      3'd1, 3'd2, 3'd3:     return FMT_SAT;
      3'd4, 3'd5:           return FMT_LIT;
      default:              return FMT_NONE;
    endcase
  endfunction

  // Brings a raw 16-bit host value into the number format of the chosen curve.
  function automatic logic [ENTRY_W-1:0] cg_condition(input logic [CODE_W-1:0] code,
                                                      input logic [ENTRY_W-1:0] raw);
    logic signed [ENTRY_W-1:0] sraw;
    sraw = $signed(raw);
    case (cg_fmt(code))
      FMT_HUE: return {{2{raw[13]}}, raw[13:0]};
      FMT_SAT: return (raw > ENTRY_W'(SAT_MAX)) ? ENTRY_W'(SAT_MAX) : raw;
      FMT_LIT: begin
        if (sraw > $signed(ENTRY_W'(LIT_MAX)))      return ENTRY_W'(LIT_MAX);
        else if (sraw < $signed(ENTRY_W'(LIT_MIN))) return ENTRY_W'(LIT_MIN);
        else                                        return raw;
      end
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/cg_ctrl.sv
module cg_ctrl
  import cg_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int NUM_TABLES = 6,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        sw_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [7:0]        hi_q,
  output logic [CODE_W-1:0] tbl_code,
  output logic              reserved,
  output logic              rd_fire,
  output logic              commit_fire,
  output logic              bump
);

  win_addr_e  win;
  logic       wr_sw, wr_idx, wr_hi, wr_lo, lo_access;

  assign win       = win_addr_e'(reg_addr);
  assign tbl_code  = sw_q[7:5];
  assign reserved  = ({1'b0, tbl_code} >= (CODE_W+1)'(NUM_TABLES));
  assign rd_fire   = reg_rd && !reg_wr;
  assign wr_sw     = reg_wr && (win == WIN_SWITCH);
  assign wr_idx    = reg_wr && (win == WIN_INDEX);
  assign wr_hi     = reg_wr && (win == WIN_HI);
  assign wr_lo     = reg_wr && (win == WIN_LO);
  assign lo_access = wr_lo || (rd_fire && (win == WIN_LO));
  assign bump      = lo_access && sw_q[0];
  assign commit_fire = wr_lo && !reserved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q  <= '0;
      idx_q <= '0;
      hi_q  <= '0;
    end else begin
      if (wr_sw) sw_q <= reg_wdata;
      if (wr_hi) hi_q <= reg_wdata;
      if (wr_idx) begin
        idx_q <= reg_wdata[IDX_W-1:0];
      end else if (bump) begin
        idx_q <= (idx_q == IDX_W'(DEPTH-1)) ? '0 : idx_q + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/cg_store.sv
module cg_store
  import cg_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int NUM_TABLES = 6,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CODE_W-1:0]  tbl,
  input  logic [IDX_W-1:0]   idx,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] rdata
);

  logic [ENTRY_W-1:0] bank_rd [NUM_TABLES];

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_bank
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic               sel;

    assign sel = (tbl == CODE_W'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else if (we && sel) begin
        mem[idx] <= wdata;
      end
    end

    assign bank_rd[t] = mem[idx];
  end

  always_comb begin
    rdata = '0;
    for (int t = 0; t < NUM_TABLES; t++) begin
      if (tbl == CODE_W'(t)) rdata = bank_rd[t];
    end
  end

endmodule

// File: rtl/cg_table_port.sv
module cg_table_port
  import cg_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int NUM_TABLES = 6,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       rd_valid
);

  logic [7:0]         sw_q, hi_q, rd_mux;
  logic [IDX_W-1:0]   idx_q;
  logic [CODE_W-1:0]  tbl_code;
  logic               reserved, rd_fire, commit_fire, bump;
  logic [ENTRY_W-1:0] entry_q, entry_new;

  cg_ctrl #(.DEPTH(DEPTH), .NUM_TABLES(NUM_TABLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .sw_q        (sw_q),
    .idx_q       (idx_q),
    .hi_q        (hi_q),
    .tbl_code    (tbl_code),
    .reserved    (reserved),
    .rd_fire     (rd_fire),
    .commit_fire (commit_fire),
    .bump        (bump)
  );

  assign entry_new = cg_condition(tbl_code, {hi_q, reg_wdata});

  cg_store #(.DEPTH(DEPTH), .NUM_TABLES(NUM_TABLES)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_fire),
    .tbl   (tbl_code),
    .idx   (idx_q),
    .wdata (entry_new),
    .rdata (entry_q)
  );

  always_comb begin
    case (win_addr_e'(reg_addr))
      WIN_SWITCH: rd_mux = sw_q;
      WIN_INDEX:  rd_mux = 8'(idx_q);
      WIN_LO:     rd_mux = reserved ? 8'h00 : entry_q[7:0];
      default:    rd_mux = reserved ? 8'h00 : entry_q[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/cg_table_port_chk.sv
module cg_table_port_chk #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             rd_valid,
  input logic [7:0]       sw_q,
  input logic [IDX_W-1:0] idx_q,
  input logic             reserved,
  input logic             rd_fire,
  input logic             commit_fire,
  input logic             bump
);

  // R4
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);

  // R4
  rd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid);

  // R7
  bump_bulk_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> sw_q[0]);

  // R7
  bump_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !(reg_wr && reg_addr == 2'd1) && idx_q != IDX_W'(DEPTH-1))
      |=> idx_q == $past(idx_q) + IDX_W'(1));

  // R8
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && idx_q == IDX_W'(DEPTH-1)) |=> idx_q == '0);

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump && !(reg_wr && reg_addr == 2'd1)) |=> $stable(idx_q));

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> idx_q == $past(reg_wdata[IDX_W-1:0]));

  // R6
  rsv_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> !reserved);

  // R6
  rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && reserved && reg_addr[1]) |=> reg_rdata == 8'h00);

endmodule

bind cg_table_port cg_table_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .rd_valid    (rd_valid),
  .sw_q        (sw_q),
  .idx_q       (idx_q),
  .reserved    (reserved),
  .rd_fire     (rd_fire),
  .commit_fire (commit_fire),
  .bump        (bump)
);

// File: tb/cg_table_port_tb.sv
module cg_table_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  localparam int DP = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rd_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  // bench model of the visible state
  logic [15:0] m_tbl [NT*DP];
  logic [7:0]  m_sw;
  int          m_idx;
  logic [7:0]  m_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  cg_table_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rd_valid  (rd_valid)
  );

  function automatic logic [15:0] ref_cond(input int code, input logic [15:0] raw);
    int v;
    if (code == 0) begin
      v = int'(raw) % 16384;
      if (v >= 8192) v = v - 16384;
    end else if (code <= 3) begin
      v = int'(raw);
      if (v > 1280) v = 1280;
    end else begin
      v = int'(raw);
      if (v >= 32768) v = v - 65536;
      if (v > 4095) v = 4095;
      if (v < -4096) v = -4096;
    end
    return 16'(v);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bw(input int addr, input logic [7:0] d);
    int code;
    code = int'(m_sw[7:5]);
    case (addr)
      0: m_sw = d;
      1: m_idx = int'(d[5:0]);
      3: m_hi = d;
      default: begin
        if (code < NT) m_tbl[code*DP + m_idx] = ref_cond(code, {m_hi, d});
        if (m_sw[0]) m_idx = (m_idx + 1) % DP;
      end
    endcase
    reg_wr = 1'b1; reg_addr = 2'(addr); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic br(input int addr, input string req);
    int code;
    logic [7:0] e;
    code = int'(m_sw[7:5]);
    case (addr)
      0: e = m_sw;
      1: e = 8'(m_idx);
      3: e = (code < NT) ? m_tbl[code*DP + m_idx][15:8] : 8'h00;
      default: begin
        e = (code < NT) ? m_tbl[code*DP + m_idx][7:0] : 8'h00;
        if (m_sw[0]) m_idx = (m_idx + 1) % DP;
      end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(req);
    reg_rd = 1'b1; reg_addr = 2'(addr);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic put16(input logic [15:0] v);
    bw(3, v[15:8]);
    bw(2, v[7:0]);
  endtask

  task automatic get16(input string req);
    br(3, req);
    br(2, req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: got unexpected read %h expected none", reg_rdata);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT*DP; i++) m_tbl[i] = '0;
    m_sw = '0; m_idx = 0; m_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 rd_valid", {7'b0, rd_valid}, 8'h00);
    br(0, "R12 switch");
    br(1, "R12 index");
    get16("R12 entry");
    br(2, "R12 entry idx0");

    // R1 switch readback with page bits, R2 index masking
    bw(0, 8'h14);
    br(0, "R1");
    bw(1, 8'hC5);
    br(1, "R2");

    // R9 hue-hue sign extension, R5 page bits ignored
    put16(16'h2534);
    get16("R9 R5");
    bw(1, 8'd7);
    put16(16'hC001);
    get16("R9");

    // R10 saturation clamp
    bw(0, 8'h20);
    bw(1, 8'd5);
    put16(16'h0600);
    get16("R10");
    bw(1, 8'd6);
    put16(16'h04FF);
    get16("R10");

    // R5 separate tables
    bw(0, 8'h60);
    bw(1, 8'd5);
    put16(16'h0400);
    get16("R5 sat-sat");
    bw(0, 8'h20);
    get16("R5 hue-sat");
    bw(0, 8'h00);
    get16("R5 hue-hue");

    // R11 lightness clamp
    bw(0, 8'h80);
    bw(1, 8'd1);
    put16(16'h8000);
    get16("R11 low");
    bw(1, 8'd2);
    put16(16'h1000);
    get16("R11 high");
    bw(1, 8'd3);
    put16(16'hF123);
    get16("R11 inside");

    // R6 reserved codes
    bw(0, 8'hC0);
    bw(1, 8'd5);
    put16(16'h1234);
    get16("R6 code6");
    bw(0, 8'hE0);
    get16("R6 code7");
    bw(0, 8'h00);
    get16("R6 storage intact");

    // R3 staging: high write alone commits nothing
    bw(1, 8'd9);
    bw(3, 8'h07);
    get16("R3 staged only");
    bw(2, 8'h08);
    get16("R3 commit");
    bw(1, 8'd10);
    bw(2, 8'h44);
    get16("R3 staged kept");

    // R7 R8 bulk write with wrap
    bw(0, 8'hA1);
    bw(1, 8'd62);
    put16(16'h0011);
    put16(16'h0022);
    put16(16'h0033);
    br(1, "R8 wrap after write");
    bw(1, 8'd62);
    get16("R7 bulk read");
    get16("R7 bulk read");
    get16("R8 bulk read wrap");
    br(1, "R8 index");
    br(3, "R7 high no move");
    br(1, "R7 high no move");

    // R7 normal mode keeps index
    bw(0, 8'hA0);
    bw(1, 8'd62);
    br(2, "R7 normal");
    br(2, "R7 normal");
    br(1, "R7 normal index");

    // R4 read colliding with write is ignored
    m_idx = 9;
    reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 2'd1; reg_wdata = 8'd9;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    check("R4 collide", {7'b0, rd_valid}, 8'h00);
    br(1, "R4 write taken");

    repeat (4) @(negedge clk);
    check("R4 all reads answered", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule